// File: doc/BRIEF.md
# Interrupt Aggregator with Paired Clear/Set Control

This block gathers interrupt requests from six peripheral sources into a pending register, gates them with a mask register, and drives one level-sensitive interrupt line toward the CPU. Each source raises or drops its pending bit with single-cycle pulses. Software reaches the block through a small 32-bit register bus that has a word address, write data and a byte-lane enable.

Software never writes mask bits or mode flags directly. Each bit is driven by a pair of command bits in the written word, one that clears and one that sets, and the clear command takes priority. One command bit in the mode register also acknowledges the pending request of the highest-numbered source. A separate disk-drive request line drives its own CPU-side interrupt output, with no masking.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mode register reads 0x80, the version register reads 0x01010101, pending and mask read 0, and `cpu_irq` and `dd_irq` are low.
- R2: Registers sit at byte offsets from `BASE_ADDR`: mode +0x0, version +0x4, pending +0x8, mask +0xC. `bus_rdata` shows the addressed register in the same cycle. Any address outside this 16-byte window reads 0, and a write to it changes nothing.
- R3: A mask write handles source i (0..5) with bit 2i as clear and bit 2i+1 as set. When both bits are 1, the clear applies. When both are 0, the mask bit keeps its value.
- R4: A mode write first takes wdata[9:0] as the new value and then adjusts it. wdata[7] clears bit 8, otherwise wdata[8] sets it. wdata[9] clears bit 7, otherwise wdata[10] sets it. wdata[12] clears bit 9, otherwise wdata[13] sets it.
- R5: A mode write with wdata[11]=1 clears pending bit 5, the highest-numbered source.
- R6: A pending write stores (old & ~lanemask) | wdata, where lanemask expands each `bus_be` bit to 8 data bits. The version register ignores writes.
- R7: `sig_pulse[i]` sets pending bit i and `clr_pulse[i]` clears it. If both arrive in the same cycle, the set wins. Pulses apply after any same-cycle register write.
- R8: `cpu_irq` is high exactly when (pending & mask) is nonzero. It follows every change to pending or mask on the next cycle.
- R9: `dd_set` raises `dd_irq` and `dd_clr` lowers it, with set winning. Mask and pending have no effect on `dd_irq`.
- R10: Pending and mask bits 31:6 and mode bits 31:10 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enable for pending writes |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| sig_pulse | input | 6 | Per-source request set |
| clr_pulse | input | 6 | Per-source request clear |
| dd_set | input | 1 | Disk-drive request set |
| dd_clr | input | 1 | Disk-drive request clear |
| cpu_irq | output | 1 | Masked interrupt level |
| dd_irq | output | 1 | Disk-drive interrupt level |

## Verification
The hardest state to reach from the ports is one where pending, mask and mode all change in the same cycle or in the cycles just before one another. Examples are a mode acknowledge that removes the only unmasked request, and a clear pulse that meets a set pulse for the same source. The bench loads pending to a chosen pattern before each command. It then sweeps the full mask command space, every mode command word of 14 bits, and every signal/clear pulse combination. After each step it checks the read-back value and the interrupt level against a model computed in the bench.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter logic [31:0] BASE_ADDR  = 32'h0430_0000,
  parameter int          NSRC       = 6,
  parameter logic [31:0] VERSION    = 32'h0101_0101,
  parameter logic [9:0]  MODE_RESET = 10'h080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic [5:0]  sig_pulse,
  input  logic [5:0]  clr_pulse,
  input  logic        dd_set,
  input  logic        dd_clr,
  output logic        cpu_irq,
  output logic        dd_irq
);
  localparam logic [1:0] IDX_MODE = 2'd0;
  localparam logic [1:0] IDX_VER  = 2'd1;
  localparam logic [1:0] IDX_PEND = 2'd2;
  localparam logic [1:0] IDX_MASK = 2'd3;
  localparam int         ACK_SRC  = NSRC - 1;

  logic [NSRC-1:0] pend_q, mask_q, pend_nx, mask_nx;
  logic [9:0]      mode_q, mode_nx;
  logic [31:0]     offset, lane_mask;
  logic            in_win;
  logic [1:0]      idx;

  assign offset    = bus_addr - BASE_ADDR;
  assign in_win    = (offset[31:4] == 28'd0);
  assign idx       = offset[3:2];
  assign lane_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  wire wr_mode = bus_wr && in_win && idx == IDX_MODE;
  wire wr_pend = bus_wr && in_win && idx == IDX_PEND;
  wire wr_mask = bus_wr && in_win && idx == IDX_MASK;

  always_comb begin
    mode_nx = bus_wdata[9:0];
    if (bus_wdata[7])       mode_nx[8] = 1'b0;
    else if (bus_wdata[8])  mode_nx[8] = 1'b1;
    if (bus_wdata[9])       mode_nx[7] = 1'b0;
    else if (bus_wdata[10]) mode_nx[7] = 1'b1;
    if (bus_wdata[12])      mode_nx[9] = 1'b0;
    else if (bus_wdata[13]) mode_nx[9] = 1'b1;
  end

  always_comb begin
    mask_nx = mask_q;
    for (int i = 0; i < NSRC; i++) begin
      if (bus_wdata[2*i])        mask_nx[i] = 1'b0;
      else if (bus_wdata[2*i+1]) mask_nx[i] = 1'b1;
    end
  end

  always_comb begin
    pend_nx = pend_q;
    if (wr_pend) pend_nx = (pend_nx & ~lane_mask[NSRC-1:0]) | bus_wdata[NSRC-1:0];
    if (wr_mode && bus_wdata[11]) pend_nx[ACK_SRC] = 1'b0;
    pend_nx = (pend_nx & ~clr_pulse) | sig_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      mask_q <= '0;
      pend_q <= '0;
      dd_irq <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_nx;
      if (wr_mask) mask_q <= mask_nx;
      pend_q <= pend_nx;
      if (dd_set)      dd_irq <= 1'b1;
      else if (dd_clr) dd_irq <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      case (idx)
        IDX_MODE: bus_rdata[9:0]      = mode_q;
        IDX_VER:  bus_rdata           = VERSION;
        IDX_PEND: bus_rdata[NSRC-1:0] = pend_q;
        default:  bus_rdata[NSRC-1:0] = mask_q;
      endcase
    end
  end

  assign cpu_irq = |(pend_q & mask_q);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter logic [31:0] BASE_ADDR = 32'h0430_0000,
  parameter int          NSRC      = 6,
  parameter logic [31:0] VERSION   = 32'h0101_0101
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [31:0]     bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [5:0]      sig_pulse,
  input logic            dd_set,
  input logic            cpu_irq,
  input logic            dd_irq,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q
);
  a_r2_version: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == BASE_ADDR + 32'd4 |-> bus_rdata == VERSION);
  a_r2_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr - BASE_ADDR) >= 32'd16 |-> bus_rdata == 32'd0);
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == BASE_ADDR + 32'd12 && bus_wdata[0] |=> !mask_q[0]);
  a_r5_ack_dp: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == BASE_ADDR && bus_wdata[11] && !sig_pulse[NSRC-1] |=> !pend_q[NSRC-1]);
  a_r7_signal_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |sig_pulse |=> (pend_q & $past(sig_pulse)) == $past(sig_pulse));
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    |(sig_pulse & mask_q) && !bus_wr |=> cpu_irq);
  a_r9_dd_set: assert property (@(posedge clk) disable iff (!rst_n)
    dd_set |=> dd_irq);
  a_r10_pend_upper: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == BASE_ADDR + 32'd8 |-> bus_rdata[31:6] == 26'd0);
endmodule

bind irq_aggregator irq_aggregator_chk #(.BASE_ADDR(BASE_ADDR), .NSRC(NSRC), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .sig_pulse(sig_pulse), .dd_set(dd_set), .cpu_irq(cpu_irq),
  .dd_irq(dd_irq), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam logic [31:0] BASE = 32'h0430_0000;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_addr = BASE, bus_wdata = '0, bus_rdata;
  logic [3:0] bus_be = 4'hF;
  logic [5:0] sig_pulse = '0, clr_pulse = '0;
  logic dd_set = 1'b0, dd_clr = 1'b0, cpu_irq, dd_irq;
  int n_chk = 0, n_err = 0;
  logic [5:0] pend_m = '0, mask_m = '0;
  logic [9:0] mode_m = 10'h080;

  always #10 clk = ~clk;

  irq_aggregator u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .sig_pulse(sig_pulse),
    .clr_pulse(clr_pulse), .dd_set(dd_set), .dd_clr(dd_clr), .cpu_irq(cpu_irq), .dd_irq(dd_irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; bus_be = 4'hF;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  function automatic logic [9:0] mode_fn(logic [31:0] w);
    logic [9:0] r = w[9:0];
    if (w[7]) r[8] = 0; else if (w[8]) r[8] = 1;
    if (w[9]) r[7] = 0; else if (w[10]) r[7] = 1;
    if (w[12]) r[9] = 0; else if (w[13]) r[9] = 1;
    return r;
  endfunction

  function automatic logic [5:0] mask_fn(logic [5:0] m, logic [31:0] w);
    for (int i = 0; i < 6; i++)
      if (w[2*i]) m[i] = 0; else if (w[2*i+1]) m[i] = 1;
    return m;
  endfunction

  task automatic check_all(string req);
    logic [31:0] d;
    rd(BASE, d);         check(req, d, {22'd0, mode_m});
    rd(BASE + 8, d);     check(req, d, {26'd0, pend_m});
    rd(BASE + 12, d);    check(req, d, {26'd0, mask_m});
    check(req, {31'd0, cpu_irq}, {31'd0, |(pend_m & mask_m)});
  endtask

  initial begin
    #4000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(BASE + 4, d); check("R1", d, 32'h0101_0101);
    check_all("R1");
    check("R1", {31'd0, dd_irq}, 32'd0);

    // R2 window edges and ignored writes
    rd(BASE + 16, d);  check("R2", d, 32'd0);
    rd(BASE - 4, d);   check("R2", d, 32'd0);
    wr(BASE + 16, 32'hFFFF_FFFF); wr(BASE - 4, 32'hFFFF_FFFF);
    check_all("R2");
    // R6 version read-only
    wr(BASE + 4, 32'h1234_5678);
    rd(BASE + 4, d); check("R6", d, 32'h0101_0101);

    // R3/R8 full mask command sweep with varying pending
    for (int w = 0; w < 4096; w++) begin
      wr(BASE + 8, w[5:0] ^ w[11:6]); pend_m = w[5:0] ^ w[11:6];
      wr(BASE + 12, w); mask_m = mask_fn(mask_m, w);
      rd(BASE + 12, d); check("R3", d, {26'd0, mask_m});
      check("R8", {31'd0, cpu_irq}, {31'd0, |(pend_m & mask_m)});
    end

    // R4/R5/R10 mode command sweep
    wr(BASE + 12, 32'h0AAA); mask_m = 6'h3F;
    for (int w = 0; w < 16384; w++) begin
      wr(BASE + 8, 32'hFFFF_FF00 | (w[5:0] | 6'h20)); pend_m = w[5:0] | 6'h20;
      wr(BASE, 32'hFFFF_C000 | w);
      mode_m = mode_fn(w);
      if (w[11]) pend_m[5] = 1'b0;
      rd(BASE, d);     check("R4", d, {22'd0, mode_m});
      rd(BASE + 8, d); check("R5", d, {26'd0, pend_m});
      check("R8", {31'd0, cpu_irq}, {31'd0, |pend_m});
    end
    rd(BASE, d); check("R10", d & 32'hFFFF_FC00, 32'd0);

    // R7 pulse sweep
    for (int s = 0; s < 64; s++)
      for (int c = 0; c < 64; c++) begin
        wr(BASE + 8, s ^ c ^ 6'h15); pend_m = 6'(s ^ c ^ 6'h15);
        @(negedge clk); sig_pulse = 6'(s); clr_pulse = 6'(c);
        @(negedge clk); sig_pulse = '0; clr_pulse = '0;
        pend_m = (pend_m & ~6'(c)) | 6'(s);
        rd(BASE + 8, d); check("R7", d, {26'd0, pend_m});
        check("R8", {31'd0, cpu_irq}, {31'd0, |pend_m});
      end

    // R7 pulse versus same-cycle bus write: pulses win
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = BASE + 8; bus_wdata = 32'h0; sig_pulse = 6'h09;
    @(negedge clk);
    bus_wr = 1'b0; sig_pulse = '0;
    rd(BASE + 8, d); check("R7", d, 32'h09);
    pend_m = 6'h09;

    // R6 lane mask sweep
    for (int be = 0; be < 16; be++) begin
      wr(BASE + 8, 32'h3F); pend_m = 6'h3F;
      wr(BASE + 8, 32'h12, 4'(be));
      pend_m = (be[0] ? 6'h00 : pend_m) | 6'h12;
      rd(BASE + 8, d); check("R6", d, {26'd0, pend_m});
    end

    // R9 disk-drive line, unaffected by mask
    wr(BASE + 12, 32'h0555); mask_m = '0;
    @(negedge clk); dd_set = 1; dd_clr = 1;
    @(negedge clk); dd_set = 0; dd_clr = 0;
    check("R9", {31'd0, dd_irq}, 32'd1);
    check("R9", {31'd0, cpu_irq}, 32'd0);
    @(negedge clk); dd_clr = 1;
    @(negedge clk); dd_clr = 0;
    check("R9", {31'd0, dd_irq}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule